// File: doc/BRIEF.md
# E1 Spare-Bit Link Collector and Inserter

This block handles the five national-use spare bits, Sa4 to Sa8, that ride in time slot 0 of the frames without the alignment word in an E1 signal. On the receive side it watches an already aligned bit stream. It is given a strobe for each bit, a marker on the first bit of every frame, a marker on the first bit of every multiframe, and a level that says whether alignment is held. It gathers the spare bits of two whole multiframes and copies the result into a read stack. It then raises a maskable interrupt, and a processor reads one 16-bit word per spare position and acknowledges.

On the transmit side the block follows a second aligned stream. Software writes a transmit stack. A 5-bit select vector decides, for each spare position separately, whether the outgoing bit comes from that stack or passes through unchanged from the system-side data input. Where the block is not the chosen source, it leaves the data alone and does not assert its drive flag.

Frame alignment, CRC-4 and HDLC work are done elsewhere. Counters and flags are all updated on one clock, and a strobe marks each line bit.

Top module: `e1_sa_link`

## Requirements
- R1: After reset, `pending`, `overrun`, `irq` and `tx_sa_drv` are 0, and every stack word reads as zero.
- R2: Frame number 0 is the frame whose start bit carries `rx_mfs`; each later `rx_fs` adds one. Within a frame, the start bit is position 0. Spare bits are taken only from odd frames, at positions 3 to 7, which are Sa4 to Sa8. `rd_sel` 0 to 4 selects Sa4 to Sa8 in that order.
- R3: In a stored word, bit j holds the spare bit from odd frame 2*(j mod 8)+1 of multiframe j/8 of the collection. Multiframe 0 is the first of the two.
- R4: A collection starts only at a multiframe marker that arrives while `rx_aligned` is 1. It spans that multiframe and the next one. It completes at the Sa8 bit of frame 15 of the second multiframe. On the following clock edge the new words appear at `rd_word` and `pending` rises. The next marker starts a fresh collection.
- R5: In any cycle with `rx_aligned` at 0, the partial collection is discarded and the stack is left unchanged. Collection resumes at the next marker that arrives while alignment is held.
- R6: `irq` equals `pending` gated by `irq_en`. `rd_ack` clears `pending` unless a collection completes in the same cycle.
- R7: If a collection completes while `pending` is 1 and `rd_ack` is 0, `overrun` is set and the stack takes the newer data. `rd_ack` clears `overrun`. A completion in the same cycle as `rd_ack` leaves `pending` at 1 and `overrun` at 0.
- R8: On the transmit side, counting follows the same rules as R2. The first `tx_mfs` starts multiframe half 0, and the half then alternates at each marker. When `tx_sel[i]` is 1, the odd-frame position 3+i outputs the transmit-stack bit of word i, using the layout of R3, and `tx_sa_drv` is 1. A write with `wr_en` and `wr_sel` below 5 replaces word `wr_sel` from the next cycle on.
- R9: At every other bit, at any position whose select bit is 0, and before the first `tx_mfs`, `tx_data_out` equals `tx_sys_data` and `tx_sa_drv` is 0.
- R10: `rd_sel` values 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive bit strobe |
| rx_data | input | 1 | Receive bit |
| rx_fs | input | 1 | Receive bit is a frame's first bit |
| rx_mfs | input | 1 | Receive bit is a multiframe's first bit |
| rx_aligned | input | 1 | Receive alignment held |
| irq_en | input | 1 | Interrupt mask, 1 enables |
| rd_ack | input | 1 | Processor acknowledge of the stack update |
| rd_sel | input | 3 | Stack word select |
| rd_word | output | 16 | Selected receive stack word |
| irq | output | 1 | Update interrupt |
| pending | output | 1 | Unacknowledged update present |
| overrun | output | 1 | Update lost before acknowledge |
| wr_en | input | 1 | Transmit stack write strobe |
| wr_sel | input | 3 | Transmit stack word select |
| wr_word | input | 16 | Transmit stack write data |
| tx_sel | input | 5 | Per-position source select, 1 takes the stack |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_fs | input | 1 | Transmit bit is a frame's first bit |
| tx_mfs | input | 1 | Transmit bit is a multiframe's first bit |
| tx_sys_data | input | 1 | System-side transmit bit |
| tx_data_out | output | 1 | Transmit bit after insertion |
| tx_sa_drv | output | 1 | Block supplies the current spare bit |

## Verification
The transmit outputs and `rd_word` follow the present inputs combinationally, so they are due in the same cycle as the stimulus. `pending`, `overrun`, the stack contents and the transmit stack words change at the edge that ends the Sa8 bit, the acknowledge or the write. The bench drives every input 1 ns after the rising edge. A behavioural model is advanced on that same edge, and all outputs are compared against the model at the falling edge. A registered result is therefore checked exactly one cycle after its cause, and a combinational result is checked in the cycle of its cause. The stimulus uses short frames, random strobe gaps, glitched alignment and random acknowledge rates. These reach back-to-back completions, overruns and an acknowledge that falls in the completion cycle.

// File: rtl/e1_sa_link.sv
module e1_sa_link #(
  parameter int SA_N     = 5,
  parameter int SA_FIRST = 3,
  parameter int MF_LEN   = 16,
  parameter int MF_PER   = 2,
  parameter int CNT_W    = 8,
  parameter int WORD_W   = MF_PER * MF_LEN / 2,
  parameter int SEL_W    = $clog2(SA_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_data,
  input  logic              rx_fs,
  input  logic              rx_mfs,
  input  logic              rx_aligned,
  input  logic              irq_en,
  input  logic              rd_ack,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic              irq,
  output logic              pending,
  output logic              overrun,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [SA_N-1:0]   tx_sel,
  input  logic              tx_valid,
  input  logic              tx_fs,
  input  logic              tx_mfs,
  input  logic              tx_sys_data,
  output logic              tx_data_out,
  output logic              tx_sa_drv
);
  localparam int FW = $clog2(MF_LEN);
  localparam int HW = (MF_PER > 1) ? $clog2(MF_PER) : 1;
  localparam int IW = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(SA_FIRST);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(SA_FIRST + SA_N - 1);
  localparam logic [FW-1:0]    F_LAST = FW'(MF_LEN - 1);
  localparam logic [HW-1:0]    H_LAST = HW'(MF_PER - 1);

  logic [CNT_W-1:0] r_cnt, t_cnt;
  logic [FW-1:0]    r_frm, t_frm;
  logic [HW-1:0]    r_half, t_half;
  logic             r_coll, t_go, pend_q, ovr_q;
  logic [SA_N-1:0][WORD_W-1:0] col_q, col_nx, stk_q, tstk_q;

  logic             r_slot, cap, done, mf_mark;
  logic [SEL_W-1:0] r_i, t_i;
  logic [IW-1:0]    r_idx, t_idx;
  logic             t_slot;

  assign mf_mark = rx_valid & rx_fs & rx_mfs;
  assign r_slot  = rx_valid & ~rx_fs & r_frm[0] & (r_cnt >= P_LO) & (r_cnt <= P_HI);
  assign cap     = r_coll & rx_aligned & r_slot;
  assign done    = cap & (r_half == H_LAST) & (r_frm == F_LAST) & (r_cnt == P_HI);
  assign r_i     = SEL_W'(r_cnt - P_LO);
  assign r_idx   = IW'({r_half, r_frm[FW-1:1]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt <= '0;
      r_frm <= '0;
    end else if (rx_valid) begin
      if (rx_fs) begin
        r_cnt <= CNT_W'(1);
        r_frm <= rx_mfs ? '0 : r_frm + 1'b1;
      end else if (r_cnt != '1) begin
        r_cnt <= r_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_coll <= 1'b0;
      r_half <= '0;
    end else if (!rx_aligned || done) begin
      r_coll <= 1'b0;
    end else if (mf_mark) begin
      if (r_coll) r_half <= r_half + 1'b1;
      else begin
        r_coll <= 1'b1;
        r_half <= '0;
      end
    end
  end

  always_comb begin
    col_nx = col_q;
    if (cap) col_nx[r_i][r_idx] = rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      stk_q <= '0;
    end else begin
      col_q <= col_nx;
      if (done) stk_q <= col_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_ack) ovr_q <= 1'b0;
      if (done) begin
        pend_q <= 1'b1;
        if (pend_q && !rd_ack) ovr_q <= 1'b1;
      end else if (rd_ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pending = pend_q;
  assign overrun = ovr_q;
  assign irq     = pend_q & irq_en;
  assign rd_word = (rd_sel < SEL_W'(SA_N)) ? stk_q[rd_sel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tstk_q <= '0;
    else if (wr_en && wr_sel < SEL_W'(SA_N)) tstk_q[wr_sel] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt  <= '0;
      t_frm  <= '0;
      t_half <= '0;
      t_go   <= 1'b0;
    end else if (tx_valid) begin
      if (tx_fs) begin
        t_cnt <= CNT_W'(1);
        t_frm <= tx_mfs ? '0 : t_frm + 1'b1;
        if (tx_mfs) begin
          t_half <= t_go ? t_half + 1'b1 : '0;
          t_go   <= 1'b1;
        end
      end else if (t_cnt != '1) begin
        t_cnt <= t_cnt + 1'b1;
      end
    end
  end

  assign t_slot      = tx_valid & t_go & ~tx_fs & t_frm[0] & (t_cnt >= P_LO) & (t_cnt <= P_HI);
  assign t_i         = SEL_W'(t_cnt - P_LO);
  assign t_idx       = IW'({t_half, t_frm[FW-1:1]});
  assign tx_sa_drv   = t_slot & tx_sel[t_i];
  assign tx_data_out = tx_sa_drv ? tstk_q[t_i][t_idx] : tx_sys_data;
endmodule

// File: rtl/e1_sa_link_chk.sv
module e1_sa_link_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic rx_fs,
  input logic rx_aligned,
  input logic rd_ack,
  input logic irq_en,
  input logic irq,
  input logic pending,
  input logic overrun,
  input logic tx_valid,
  input logic tx_fs,
  input logic tx_sys_data,
  input logic tx_data_out,
  input logic tx_sa_drv
);
  // R4
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(rx_valid && rx_aligned && !rx_fs));
  // R5
  unaligned_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_aligned |=> !$rose(pending));
  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !rd_ack |=> pending);
  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R7
  ovr_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(pending));
  // R7
  ack_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !overrun);
  // R8
  drv_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sa_drv |-> tx_valid && !tx_fs);
  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sa_drv |-> tx_data_out == tx_sys_data);
endmodule

bind e1_sa_link e1_sa_link_chk u_chk (.*);

// File: tb/e1_sa_link_tb.sv
module e1_sa_link_tb;
  localparam int FL = 12;

  bit clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0;
  logic rx_valid = 0, rx_data = 0, rx_fs = 0, rx_mfs = 0, rx_aligned = 0;
  logic irq_en = 1, rd_ack = 0;
  logic [2:0] rd_sel = 0;
  logic [15:0] rd_word;
  logic irq, pending, overrun;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [15:0] wr_word = 0;
  logic [4:0] tx_sel = 5'b10110;
  logic tx_valid = 0, tx_fs = 0, tx_mfs = 0, tx_sys_data = 0;
  logic tx_data_out, tx_sa_drv;

  e1_sa_link u_dut (.*);

  int compared = 0, mismatched = 0;
  bit chk_on = 0;
  string phase = "R1";

  logic [15:0] mcol [5];
  logic [15:0] mstk [5];
  logic [15:0] mtx  [5];
  int rnext = 0, rfrm = 0, mhalf = 0, tnext = 0, tfrm = 0, thalf = 0;
  bit mcoll = 0, mpend = 0, movr = 0, tgo = 0;
  int rg_pos = 0, rg_frm = 0, tg_pos = 5, tg_frm = 3;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int pos, frm;
    bit dn;
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin mcol[k] = 0; mstk[k] = 0; mtx[k] = 0; end
      rnext = 0; rfrm = 0; mhalf = 0; mcoll = 0; mpend = 0; movr = 0;
      tnext = 0; tfrm = 0; thalf = 0; tgo = 0;
    end else begin
      dn = 0;
      if (rx_valid) begin
        pos = rx_fs ? 0 : rnext;
        frm = rx_fs ? (rx_mfs ? 0 : (rfrm + 1) % 16) : rfrm;
        if (mcoll && rx_aligned && !rx_fs && frm % 2 == 1 && pos >= 3 && pos <= 7) begin
          mcol[pos-3][mhalf*8 + frm/2] = rx_data;
          if (mhalf == 1 && frm == 15 && pos == 7) dn = 1;
        end
        rnext = (pos < 255) ? pos + 1 : 255;
        rfrm = frm;
      end
      if (!rx_aligned || dn) mcoll = 0;
      else if (rx_valid && rx_fs && rx_mfs) begin
        if (mcoll) mhalf = (mhalf + 1) % 2;
        else begin mcoll = 1; mhalf = 0; end
      end
      if (rd_ack) movr = 0;
      if (dn) begin
        if (mpend && !rd_ack) movr = 1;
        mpend = 1;
        for (int k = 0; k < 5; k++) mstk[k] = mcol[k];
      end else if (rd_ack) mpend = 0;
      if (wr_en && wr_sel < 5) mtx[wr_sel] = wr_word;
      if (tx_valid) begin
        if (tx_fs) begin
          tnext = 1;
          tfrm = tx_mfs ? 0 : (tfrm + 1) % 16;
          if (tx_mfs) begin thalf = tgo ? (thalf ^ 1) : 0; tgo = 1; end
        end else tnext = (tnext < 255) ? tnext + 1 : 255;
      end
    end
  end

  always @(negedge clk) begin
    bit edrv;
    logic eout;
    if (chk_on) begin
      chk("R6", "irq", irq, mpend && irq_en);
      chk("R6", "pending", pending, mpend);
      chk("R7", "overrun", overrun, movr);
      if (rd_sel > 4) chk("R10", "rd_word", rd_word, 0);
      else chk(phase, "rd_word", rd_word, mstk[rd_sel]);
      edrv = 0;
      if (tx_valid && tgo && !tx_fs && tfrm % 2 == 1 && tnext >= 3 && tnext <= 7)
        edrv = tx_sel[tnext-3];
      eout = edrv ? mtx[tnext-3][thalf*8 + tfrm/2] : tx_sys_data;
      chk(edrv ? "R8" : "R9", "tx_sa_drv", tx_sa_drv, edrv);
      chk(edrv ? "R8" : "R9", "tx_data_out", tx_data_out, eout);
    end
  end

  task automatic cyc(int n, int ack_rate);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = ($urandom % 4) != 0;
      rx_data = $urandom;
      if (rx_valid) begin
        rx_fs = (rg_pos == 0);
        rx_mfs = (rg_pos == 0 && rg_frm == 0);
        rg_pos++;
        if (rg_pos == FL) begin rg_pos = 0; rg_frm = (rg_frm + 1) % 16; end
      end else begin
        rx_fs = $urandom; rx_mfs = $urandom;
      end
      tx_valid = ($urandom % 3) != 0;
      tx_sys_data = $urandom;
      if (tx_valid) begin
        tx_fs = (tg_pos == 0);
        tx_mfs = (tg_pos == 0 && tg_frm == 0);
        tg_pos++;
        if (tg_pos == FL) begin tg_pos = 0; tg_frm = (tg_frm + 1) % 16; end
      end else begin
        tx_fs = $urandom; tx_mfs = $urandom;
      end
      rd_ack = (ack_rate > 0) && (($urandom % ack_rate) == 0);
      rd_sel = $urandom % 8;
      wr_en = ($urandom % 6) == 0;
      wr_sel = $urandom % 8;
      wr_word = $urandom;
      if (($urandom % 64) == 0) tx_sel = $urandom;
      if (($urandom % 50) == 0) irq_en = ~irq_en;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(posedge clk); #1;
    chk_on = 1;
    @(negedge clk);
    chk("R1", "pending", pending, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "tx_sa_drv", tx_sa_drv, 0);
    for (int k = 0; k < 8; k++) begin
      rd_sel = k; #0.1;
      chk("R1", "rd_word", rd_word, 0);
    end
    @(posedge clk); #1;
    rst_n = 1;
    rx_aligned = 1;
    phase = "R4";
    cyc(800, 0);
    phase = "R2";
    cyc(10, 1);
    phase = "R3";
    cyc(1600, 0);
    phase = "R5";
    cyc(150, 3);
    rx_aligned = 0;
    cyc(4, 3);
    rx_aligned = 1;
    cyc(300, 3);
    rx_aligned = 0;
    cyc(1, 0);
    rx_aligned = 1;
    cyc(1200, 40);
    phase = "R7";
    cyc(6000, 30);
    phase = "R8";
    tx_sel = 5'b11111;
    cyc(1500, 20);
    phase = "R9";
    tx_sel = 5'b00000;
    cyc(500, 20);
    finish_run();
  end
endmodule